// File: doc/BRIEF.md
# Per-Channel Audio Auto-Mute Detector

This block monitors the two channel streams of one parallel audio input port and decides, for each channel on its own, when that channel has gone silent. A channel counts as silent once it has carried a long unbroken run of samples that are either entirely zero or entirely one. Samples arrive as a word with a valid strobe and a left/right select. The block keeps a saturating run counter for each channel and reports a level flag while the channel stays muted.

On the sample that completes a run, the block also raises a single-cycle entry pulse. An interrupt status register downstream latches this pulse as an edge event. Any sample with mixed bits ends the run at once. An enable input switches detection off and clears all state.

Top module: `automute_det`

## Requirements
- R1: After reset, `mute_o` and `entry_o` are both 2'b00. Bit 0 is the left channel and bit 1 is the right channel.
- R2: A sample whose bits are neither all 0 nor all 1 resets the run of its channel. `mute_o` for that channel is low from the clock edge that captures the sample.
- R3: `lr_i`=0 steers a sample to the left channel (bit 0) and `lr_i`=1 steers it to the right channel (bit 1). A sample never changes the other channel's flag, pulse or run.
- R4: `mute_o` for a channel goes high at the edge that captures the 4096th consecutive qualifying sample of that channel. It stays low after 4095 such samples.
- R5: A run only counts samples of one kind. When an all-ones sample follows all-zero samples, or the other way round, the count restarts at one and the channel's mute flag drops.
- R6: The run counter saturates at 4096. Further samples of the same kind keep `mute_o` high and raise no new entry pulse.
- R7: `entry_o` for a channel is high for exactly one clock cycle. That cycle is the one in which `mute_o` for the channel rises.
- R8: While `en_i` is low, both counters, flags and pulses are held at zero and samples are ignored. After `en_i` returns high, a full new run of 4096 samples is needed.
- R9: A cycle with `valid_i` low leaves both flags unchanged and produces no entry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detection enable |
| valid_i | input | 1 | Sample strobe |
| lr_i | input | 1 | Channel select, 0 left, 1 right |
| sample_i | input | SAMPLE_W | Sample word |
| mute_o | output | 2 | Per-channel mute flag |
| entry_o | output | 2 | Per-channel one-cycle mute-entry pulse |

## Verification
A wrong run count shows up only at the run boundary. A count that is off by one moves the rise of `mute_o` and `entry_o` one sample early or late, so the bench compares every sample against a model and probes exactly 4095 and 4096 samples. A stale run kind or a missed reset is only visible on a later run, so the bench switches kind in mid-run, breaks runs with mixed words and follows each with a fresh run. Crosstalk between channels or a counter that wraps shows up on the next sample, as a flag or pulse on the wrong bit or a second entry pulse during a long silence.

// File: rtl/automute_pkg.sv
package automute_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    KIND_MIX  = 2'd0,
    KIND_ZERO = 2'd1,
    KIND_ONES = 2'd2
  } run_kind_e;
endpackage

// File: rtl/amute_classify.sv
module amute_classify
  import automute_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output run_kind_e           kind_o
);
  always_comb begin
    if (~|sample_i)     kind_o = KIND_ZERO;
    else if (&sample_i) kind_o = KIND_ONES;
    else                kind_o = KIND_MIX;
  end
endmodule

// File: rtl/amute_chan.sv
module amute_chan
  import automute_pkg::*;
#(
  parameter int unsigned RUN_LEN = 4096,
  localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      hit_i,
  input  run_kind_e kind_i,
  output logic      mute_o,
  output logic      entry_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  run_kind_e        kind_q, kind_d;
  logic             mute_q, mute_d;
  logic             entry_q, entry_d;

  always_comb begin
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    mute_d  = mute_q;
    entry_d = 1'b0;
    if (!en_i) begin
      cnt_d  = '0;
      kind_d = KIND_MIX;
      mute_d = 1'b0;
    end else if (hit_i) begin
      if (kind_i == KIND_MIX) begin
        cnt_d  = '0;
        kind_d = KIND_MIX;
      end else if (kind_i == kind_q && cnt_q != '0) begin
        // saturate so a long silence never wraps
        cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin
        cnt_d  = CNT_W'(1);
        kind_d = kind_i;
      end
      mute_d  = (cnt_d == CNT_MAX);
      entry_d = (cnt_d == CNT_MAX) && (cnt_q != CNT_MAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      kind_q  <= KIND_MIX;
      mute_q  <= 1'b0;
      entry_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      mute_q  <= mute_d;
      entry_q <= entry_d;
    end
  end

  assign mute_o  = mute_q;
  assign entry_o = entry_q;
endmodule

// File: rtl/automute_det.sv
module automute_det
  import automute_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RUN_LEN  = 4096
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic                lr_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [NUM_CH-1:0]   mute_o,
  output logic [NUM_CH-1:0]   entry_o
);
  run_kind_e kind;

  amute_classify #(.SAMPLE_W(SAMPLE_W)) u_classify (
    .sample_i (sample_i),
    .kind_o   (kind)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = valid_i && (lr_i == c[0]);

    amute_chan #(.RUN_LEN(RUN_LEN)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .hit_i   (hit),
      .kind_i  (kind),
      .mute_o  (mute_o[c]),
      .entry_o (entry_o[c])
    );
  end
endmodule

// File: rtl/automute_det_chk.sv
module automute_det_chk
  import automute_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                valid_i,
  input logic                lr_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic [NUM_CH-1:0]   mute_o,
  input logic [NUM_CH-1:0]   entry_o
);
  logic mixed;
  assign mixed = (|sample_i) && !(&sample_i);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (mute_o == '0) && (entry_o == '0));

  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valid_i) |=> $stable(mute_o) && (entry_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7
    entry_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      entry_o[c] |-> mute_o[c] && !$past(mute_o[c]));

    // R7
    entry_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      entry_o[c] |=> !entry_o[c]);

    // R2
    mixed_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && valid_i && (lr_i == c[0]) && mixed) |=> !mute_o[c]);

    // R3
    other_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && valid_i && (lr_i != c[0])) |=> $stable(mute_o[c]) && !entry_o[c]);
  end
endmodule

bind automute_det automute_det_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .valid_i  (valid_i),
  .lr_i     (lr_i),
  .sample_i (sample_i),
  .mute_o   (mute_o),
  .entry_o  (entry_o)
);

// File: tb/automute_det_bench.sv
module automute_det_bench;
  localparam int unsigned SW  = 24;
  localparam int unsigned RUN = 4096;
  localparam logic [SW-1:0] ZERO = '0;
  localparam logic [SW-1:0] ONES = '1;

  typedef struct {
    logic [1:0] mute;
    logic [1:0] entry;
    string      tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b1;
  logic          valid_i = 1'b0;
  logic          lr_i = 1'b0;
  logic [SW-1:0] sample_i = '0;
  logic [1:0]    mute_o, entry_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // model state: kind 0 mixed/none, 1 zero, 2 ones
  int m_cnt[2];
  int m_kind[2];

  always #2 clk_i = ~clk_i;

  automute_det #(.SAMPLE_W(SW), .RUN_LEN(RUN)) u_automute_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
    .lr_i(lr_i), .sample_i(sample_i), .mute_o(mute_o), .entry_o(entry_o)
  );

  function automatic logic [1:0] m_mute();
    return {m_cnt[1] == RUN, m_cnt[0] == RUN};
  endfunction

  task automatic compare(input logic [1:0] em, input logic [1:0] ee, input string tag);
    checks++;
    if (mute_o !== em || entry_o !== ee) begin
      errors++;
      $display("FAIL %s: mute=%b entry=%b expected mute=%b entry=%b", tag, mute_o, entry_o, em, ee);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.mute, e.entry, e.tag);
    end
  end

  task automatic push(input logic [1:0] ent, input string tag);
    exp_t e;
    e.mute = m_mute(); e.entry = ent; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic lr, input logic [SW-1:0] s, input string tag);
    int k, old;
    logic [1:0] ent;
    @(negedge clk_i);
    valid_i = 1'b1; lr_i = lr; sample_i = s;
    @(posedge clk_i); #1;
    ent = 2'b00;
    if (en_i) begin
      k = (s == ZERO) ? 1 : (s == ONES) ? 2 : 0;
      old = m_cnt[lr];
      if (k == 0) begin m_cnt[lr] = 0; m_kind[lr] = 0; end
      else if (k == m_kind[lr] && old != 0) begin
        if (old < RUN) m_cnt[lr] = old + 1;
      end else begin m_cnt[lr] = 1; m_kind[lr] = k; end
      if (m_cnt[lr] == RUN && old != RUN) ent[lr] = 1'b1;
    end
    push(ent, tag);
  endtask

  task automatic run(input logic lr, input logic [SW-1:0] s, input int n, input string tag);
    for (int i = 0; i < n; i++) send(lr, s, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); valid_i = 1'b0;
      @(posedge clk_i); #1;
      push(2'b00, tag);
    end
  endtask

  task automatic set_en(input logic v, input string tag);
    @(negedge clk_i); en_i = v; valid_i = 1'b0;
    @(posedge clk_i); #1;
    if (!v) for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_kind[c] = 0; end
    push(2'b00, tag);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_kind[c] = 0; end
    repeat (3) @(negedge clk_i);
    compare(2'b00, 2'b00, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare(2'b00, 2'b00, "R1");

    run(1'b0, ZERO, RUN - 1, "R4");
    run(1'b0, ZERO, 1, "R4");         // left mutes with pulse
    idle(2, "R7");
    run(1'b0, ZERO, 50, "R6");
    run(1'b1, ONES, 10, "R3");
    run(1'b0, 24'h000100, 1, "R2");
    run(1'b1, ONES, 3000, "R5");
    run(1'b1, ZERO, RUN - 1, "R5");   // restarted at one: still short
    run(1'b1, ZERO, 1, "R5");
    run(1'b1, ONES, 1, "R5");         // switch while muted drops flag
    run(1'b1, 24'hFFFFFE, 1, "R2");
    for (int i = 0; i < RUN; i++) begin
      send(1'b0, ONES, "R3");
      send(1'b1, 24'h000001, "R3");
    end
    idle(5, "R9");
    set_en(1'b0, "R8");
    run(1'b0, ZERO, 20, "R8");
    run(1'b1, ONES, 20, "R8");
    set_en(1'b1, "R8");
    run(1'b0, ZERO, RUN - 1, "R8");
    run(1'b0, ZERO, 1, "R4");
    run(1'b0, ZERO, 1, "R7");
    idle(3, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule